// File: doc/BRIEF.md
# Stride-Stepped Indexed Table Reader

This block gives a register bus read access to a set of small internal tables, such as per-channel configuration and state arrays, that have no address space of their own. Software first programs a control register with a starting position and a stride. Each later read from any table-backed CSR address returns the word at the current position in the table that the address selects. The shared position then moves forward by the stride, wrapping modulo 256.

With position 0 and stride 1, a run of reads at one fixed address dumps a whole table in order. With stride 0, the same entry can be polled repeatedly. The block decodes the control address and one address per table. It drives the current position and a one-hot table select to the tables' read ports and registers the returned word, so data appears one cycle after the read strobe. All other addresses read as zero, and writes to them are dropped.

Top module: `idx_csr_reader`

## Requirements
- R1: After reset the position and the stride are both 0, `csr_rvalid` is low and `csr_rdata` is zero.
- R2: A write to the control address (`CTRL_ADDR`, default 0x00) loads the position from write-data bits [7:0] and the stride from bits [15:8]. Bits above 15 are ignored.
- R3: A read of the control address returns the position in bits [7:0] and the stride in bits [15:8], with zeros above. It leaves both unchanged.
- R4: A read of table address `MEM_BASE + k` (default base 0x10, k from 0 to `NUM_TABLES-1`) returns entry number (position) of table k. Bit 0 of `tbl_rd_sel` selects table 0.
- R5: After every table read, the position becomes (position + stride) mod 256. The next cycle's read already uses the new value, so back-to-back reads return consecutive entries.
- R6: A table read at a position of `TBL_DEPTH` (default 16) or more returns zero, and the position still advances.
- R7: Reads of the control address or of unmapped addresses, and writes to any address other than the control address, leave the position and the stride unchanged. Unmapped reads return zero.
- R8: Every read strobe produces exactly one cycle of `csr_rvalid`, in the cycle after the strobe. No other cycle has `csr_rvalid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_rd | input | 1 | Read strobe, one cycle per read |
| csr_wr | input | 1 | Write strobe |
| csr_addr | input | ADDR_W | CSR address |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Registered read data |
| csr_rvalid | output | 1 | Read data valid, one cycle after `csr_rd` |
| tbl_rd_idx | output | 8 | Current position sent to every table |
| tbl_rd_sel | output | NUM_TABLES | One-hot table read select, active during a table read |
| tbl_rd_data | input | NUM_TABLES*DATA_W | Combinational read words from the tables, table k at bits [k*DATA_W +: DATA_W] |

## Verification
A wrong position or stride shows up at the ports at the very next table read, either as the wrong entry or as a zero where data was expected. It is also visible right away through a read of the control address. An advance that happens on the wrong kind of access is therefore caught at the first table read that follows it. A timing slip of the return register shows up as a missing or doubled `csr_rvalid` pulse. It also shows as stale data during back-to-back reads, one cycle after the strobe.

// File: rtl/ixr_pkg.sv
`timescale 1ns/1ps
package ixr_pkg;
  localparam int IDX_W = 8;
  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_CTRL = 2'd1,
    HIT_MEM  = 2'd2
  } hit_e;

  // position after one table read: wraps modulo 2**IDX_W
  function automatic idx_t idx_step(idx_t cur, idx_t stride);
    return idx_t'(cur + stride);
  endfunction

  // true when the position addresses a real table entry
  function automatic logic idx_in_table(idx_t cur, int unsigned depth);
    return 32'(cur) < depth;
  endfunction
endpackage

// File: rtl/ixr_addr_dec.sv
`timescale 1ns/1ps
module ixr_addr_dec
  import ixr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_TABLES = 3,
  parameter int CTRL_ADDR  = 0,
  parameter int MEM_BASE   = 16
) (
  input  logic [ADDR_W-1:0]     addr,
  output hit_e                  hit,
  output logic [NUM_TABLES-1:0] tbl_sel
);
  for (genvar k = 0; k < NUM_TABLES; k++) begin : g_tdec
    assign tbl_sel[k] = (addr == ADDR_W'(MEM_BASE + k));
  end

  always_comb begin
    if (|tbl_sel)                         hit = HIT_MEM;
    else if (addr == ADDR_W'(CTRL_ADDR))  hit = HIT_CTRL;
    else                                  hit = HIT_NONE;
  end
endmodule

// File: rtl/ixr_idx_reg.sv
`timescale 1ns/1ps
module ixr_idx_reg
  import ixr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [15:0] load_val,
  input  logic        advance,
  output idx_t        idx,
  output idx_t        stride
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      stride <= '0;
    end else if (load) begin
      idx    <= load_val[7:0];
      stride <= load_val[15:8];
    end else if (advance) begin
      idx    <= idx_step(idx, stride);
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx == $past(load_val[7:0]) && stride == $past(load_val[15:8])));

  p_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (idx == idx_step($past(idx), $past(stride)) && $stable(stride)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load) |=> ($stable(idx) && $stable(stride)));
endmodule

// File: rtl/ixr_rd_ret.sv
`timescale 1ns/1ps
module ixr_rd_ret
  import ixr_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int NUM_TABLES = 3,
  parameter int TBL_DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd,
  input  hit_e                         hit,
  input  logic [NUM_TABLES-1:0]        tbl_sel,
  input  idx_t                         idx,
  input  idx_t                         stride,
  input  logic [NUM_TABLES*DATA_W-1:0] tbl_data,
  output logic [DATA_W-1:0]            rdata,
  output logic                         rvalid
);
  localparam int PAD_W = DATA_W - 2*IDX_W;

  logic [DATA_W-1:0] or_chain [NUM_TABLES+1];
  logic [DATA_W-1:0] mem_word;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] next_word;
  logic              in_range;

  assign or_chain[0] = '0;
  for (genvar k = 0; k < NUM_TABLES; k++) begin : g_mux
    assign or_chain[k+1] = or_chain[k] |
      (tbl_data[k*DATA_W +: DATA_W] & {DATA_W{tbl_sel[k]}});
  end

  assign in_range  = idx_in_table(idx, TBL_DEPTH);
  assign mem_word  = in_range ? or_chain[NUM_TABLES] : '0;
  assign ctrl_word = {{PAD_W{1'b0}}, stride, idx};

  always_comb begin
    unique case (hit)
      HIT_MEM:  next_word = mem_word;
      HIT_CTRL: next_word = ctrl_word;
      default:  next_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= next_word;
    end
  end

  p_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);

  p_norvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid);

  p_oor_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit == HIT_MEM && !in_range) |=> (rdata == '0));

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit == HIT_NONE) |=> (rdata == '0));
endmodule

// File: rtl/idx_csr_reader.sv
`timescale 1ns/1ps
module idx_csr_reader
  import ixr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 64,
  parameter int NUM_TABLES = 3,
  parameter int TBL_DEPTH  = 16,
  parameter int CTRL_ADDR  = 0,
  parameter int MEM_BASE   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         csr_rd,
  input  logic                         csr_wr,
  input  logic [ADDR_W-1:0]            csr_addr,
  input  logic [DATA_W-1:0]            csr_wdata,
  output logic [DATA_W-1:0]            csr_rdata,
  output logic                         csr_rvalid,
  output logic [7:0]                   tbl_rd_idx,
  output logic [NUM_TABLES-1:0]        tbl_rd_sel,
  input  logic [NUM_TABLES*DATA_W-1:0] tbl_rd_data
);
  hit_e                  hit;
  logic [NUM_TABLES-1:0] tbl_sel;
  logic                  mem_rd_hit;
  logic                  ctrl_wr_hit;
  idx_t                  idx;
  idx_t                  stride;
  logic                  unused_wdata_hi;

  assign unused_wdata_hi = ^csr_wdata[DATA_W-1:16];

  ixr_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_TABLES(NUM_TABLES),
    .CTRL_ADDR(CTRL_ADDR), .MEM_BASE(MEM_BASE)
  ) u_dec (
    .addr(csr_addr), .hit(hit), .tbl_sel(tbl_sel)
  );

  assign mem_rd_hit  = csr_rd && (hit == HIT_MEM);
  assign ctrl_wr_hit = csr_wr && (hit == HIT_CTRL);

  ixr_idx_reg u_idx (
    .clk(clk), .rst_n(rst_n),
    .load(ctrl_wr_hit), .load_val(csr_wdata[15:0]),
    .advance(mem_rd_hit),
    .idx(idx), .stride(stride)
  );

  ixr_rd_ret #(
    .DATA_W(DATA_W), .NUM_TABLES(NUM_TABLES), .TBL_DEPTH(TBL_DEPTH)
  ) u_ret (
    .clk(clk), .rst_n(rst_n),
    .rd(csr_rd), .hit(hit), .tbl_sel(tbl_sel),
    .idx(idx), .stride(stride),
    .tbl_data(tbl_rd_data),
    .rdata(csr_rdata), .rvalid(csr_rvalid)
  );

  assign tbl_rd_idx = idx;
  assign tbl_rd_sel = tbl_sel & {NUM_TABLES{csr_rd}};

  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tbl_rd_sel));

  p_ctrl_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && hit == HIT_CTRL) |=> (csr_rdata[15:0] == {$past(stride), $past(idx)}));
endmodule

// File: tb/idx_csr_reader_test.sv
`timescale 1ns/1ps
module idx_csr_reader_test;
  localparam int AW = 8, DW = 64, NT = 3, DEPTH = 16, CTRL = 0, BASE = 16;

  logic clk = 0, rst_n = 0, csr_rd = 0, csr_wr = 0;
  logic [AW-1:0] csr_addr = '0;
  logic [DW-1:0] csr_wdata = '0;
  logic [DW-1:0] csr_rdata;
  logic csr_rvalid;
  logic [7:0] tbl_rd_idx;
  logic [NT-1:0] tbl_rd_sel;
  logic [NT*DW-1:0] tbl_rd_data;

  int errors = 0, checks = 0;
  logic [7:0] m_idx = 0, m_inc = 0;

  always #2.5 clk = ~clk;

  idx_csr_reader #(.ADDR_W(AW), .DATA_W(DW), .NUM_TABLES(NT), .TBL_DEPTH(DEPTH),
                   .CTRL_ADDR(CTRL), .MEM_BASE(BASE)) uut (.*);

  function automatic logic [DW-1:0] pat(int t, int e);
    return {8'hC0 + 8'(t), 24'h5A5A00, 16'(t*37 + e*11 + 1), 8'(e), 8'(t)};
  endfunction

  // table models: they answer for the low position bits only
  always_comb
    for (int k = 0; k < NT; k++) tbl_rd_data[k*DW +: DW] = pat(k, int'(tbl_rd_idx[3:0]));

  function automatic logic [DW-1:0] exp_mem(int t, logic [7:0] p);
    return (p < DEPTH) ? pat(t, p) : '0;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); csr_wr = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_wr = 0;
    if (a == CTRL) begin m_idx = d[7:0]; m_inc = d[15:8]; end
  endtask

  // one read; result checked one cycle after the strobe
  task automatic rd(logic [AW-1:0] a, string req);
    logic [DW-1:0] e;
    @(negedge clk); csr_rd = 1; csr_addr = a;
    if (a == CTRL) e = {48'b0, m_inc, m_idx};
    else if (a >= BASE && a < BASE + NT) begin
      e = exp_mem(a - BASE, m_idx); m_idx = m_idx + m_inc;
    end else e = '0;
    @(negedge clk); csr_rd = 0;
    chk({req, " rvalid"}, DW'(csr_rvalid), DW'(1));
    chk(req, csr_rdata, e);
  endtask

  // back-to-back reads of one table address
  task automatic burst(int t, int n, string req);
    logic [DW-1:0] e;
    @(negedge clk); csr_addr = AW'(BASE + t); csr_rd = 1;
    for (int i = 0; i < n; i++) begin
      e = exp_mem(t, m_idx); m_idx = m_idx + m_inc;
      if (i == n-1) begin @(negedge clk); csr_rd = 0; end
      else @(negedge clk);
      chk(req, csr_rdata, e);
      chk({req, " rvalid"}, DW'(csr_rvalid), DW'(1));
    end
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rvalid", DW'(csr_rvalid), 0);
    chk("R1 rdata", csr_rdata, 0);
    rd(CTRL, "R1 ctrl after reset");
    // R2 load, upper bits ignored; R3 readback
    wr(CTRL, 64'hFFFF_FFFF_FFFF_0100);
    rd(CTRL, "R3 ctrl readback");
    // R4/R5 sequential dump of each table
    for (int t = 0; t < NT; t++) begin
      wr(CTRL, 64'h0100);
      burst(t, DEPTH, "R5 dump");
    end
    @(negedge clk);
    chk("R8 rvalid drops", DW'(csr_rvalid), 0);
    // R6 beyond depth, still advances; R5 wrap
    wr(CTRL, 64'h05FC);
    rd(AW'(BASE+1), "R6 out of range");
    rd(AW'(BASE+1), "R5 wrap to 1");
    rd(CTRL, "R5 position after wrap");
    // R7 ordinary reads and foreign writes leave position
    wr(CTRL, 64'h0203);
    rd(CTRL, "R7 ctrl read");
    rd(8'h7F, "R7 unmapped zero");
    wr(AW'(BASE), 64'h0000_00FF);
    wr(8'h40, 64'hABCD);
    rd(AW'(BASE+2), "R7 position kept");
    // R4 stride zero polls same entry
    wr(CTRL, 64'h0009);
    burst(0, 3, "R4 stride zero");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 2) wr(CTRL, {$urandom(), $urandom()});
      else if (op < 6) rd(AW'(BASE + $urandom_range(0, NT-1)), "R4 random table read");
      else if (op == 6) burst($urandom_range(0, NT-1), $urandom_range(2, 5), "R5 random burst");
      else if (op == 7) rd(CTRL, "R3 random ctrl read");
      else if (op == 8) rd(AW'($urandom_range(32, 255)), "R7 random unmapped");
      else wr(AW'($urandom_range(1, 255)), {$urandom(), $urandom()});
    end
    rd(CTRL, "R7 final state");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule